// File: doc/BRIEF.md
# Multi-Channel Interrupt Status Aggregator

This block gathers the pending interrupt sources of several serial channels and folds them into one 32-bit read-only status word, so that a host can find every channel that needs attention, and the most urgent cause inside each one, with a single read. Each channel presents a five-bit request vector. The block registers two things per channel: a one-bit summary flag and a 3-bit code that names the highest-priority source still pending.

A separate wake-up input marks the return from a low-power state. It raises a pending flag that drives the interrupt output but occupies no bit of the status word. A read whose byte enables include lane 0 clears that flag. Channel flags are never cleared by reads; they follow the source requests, which are cleared inside each channel.

Top module: `irq_status_agg`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rd_data` is 0x00000000 and `irq_out` is 0.
- R2: Bits 7:4 and bits 31:20 of `rd_data` are always 0.
- R3: Bit n of `rd_data` (n = 0..3) is 1 exactly when any bit of channel n's request slice `src_req[5n+4:5n]` was 1 at the previous clock edge.
- R4: Channel n's 3-bit code sits at `rd_data[8+3n+2 : 8+3n]`, so channel 0 uses bits 10:8 and channel 3 uses bits 19:17.
- R5: Within a request slice, bit 0 is line status, bit 1 receive data, bit 2 receive timeout, bit 3 transmit empty and bit 4 modem status. The code names the lowest-numbered set bit: line status 1, receive data 2, receive timeout 3, transmit empty 4, modem status 5, and 0 when none is set.
- R6: A read (`rd_en` high, any byte enables) does not change any summary bit or code.
- R7: A `wake_evt` pulse sets a wake-pending flag at the next edge, which drives `irq_out` high. The flag does not appear in `rd_data`, so bits 7:0 read 0x00 when no channel is pending.
- R8: A read with `rd_be[0]` high clears the wake-pending flag at the next edge. A read with `rd_be[0]` low leaves it set.
- R9: When `wake_evt` and a clearing read arrive in the same cycle, the wake-pending flag is set after that edge.
- R10: `irq_out` is 1 exactly when any summary bit in `rd_data[3:0]` is 1 or the wake-pending flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 20 | Per-channel source requests, 5 bits per channel, channel 0 lowest |
| wake_evt | input | 1 | One-cycle wake-up event |
| rd_en | input | 1 | Host read strobe |
| rd_be | input | 4 | Byte enables of the read; bit 0 covers bits 7:0 |
| rd_data | output | 32 | Packed status word |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: four channels of five sources each, packed into a 32-bit word. With these values the top channel's code field lands on bits 19:17, directly below the reserved span, so any misplacement of a field is caught by the reserved-bit checks. The default source count also lets every single-source pattern and the full priority ladder be driven on each channel. Reads are issued with and without byte lane 0, and some coincide with wake-up events, to exercise the clearing and override paths.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NUM_CH    = 4;
    localparam int NUM_SRC   = 5;
    localparam int CODE_W    = 3;
    localparam int WORD_W    = 32;
    localparam int CODE_BASE = 8;

    typedef enum logic [CODE_W-1:0] {
        SRC_NONE    = 3'd0,
        SRC_LINE    = 3'd1,
        SRC_RXDATA  = 3'd2,
        SRC_RXTMO   = 3'd3,
        SRC_TXEMPTY = 3'd4,
        SRC_MODEM   = 3'd5
    } src_code_e;

    typedef struct packed {
        logic      pend;
        src_code_e code;
    } chan_stat_t;

    // Lowest request bit has highest priority.
    function automatic src_code_e pick_code(input logic [NUM_SRC-1:0] req);
        src_code_e c;
        if (req[0])      c = SRC_LINE;
        else if (req[1]) c = SRC_RXDATA;
        else if (req[2]) c = SRC_RXTMO;
        else if (req[3]) c = SRC_TXEMPTY;
        else if (req[4]) c = SRC_MODEM;
        else             c = SRC_NONE;
        return c;
    endfunction

endpackage

// File: rtl/irq_chan_enc.sv
module irq_chan_enc
    import irq_agg_pkg::*;
#(
    parameter int SRC_N = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] req,
    output chan_stat_t       stat
);
    chan_stat_t stat_d;

    always_comb begin
        stat_d.pend = |req;
        stat_d.code = pick_code(req);
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '{pend: 1'b0, code: SRC_NONE};
        else     stat <= stat_d;
    end
endmodule

// File: rtl/irq_wake_flag.sv
module irq_wake_flag (
    input  logic clk,
    input  logic rst,
    input  logic wake_evt,
    input  logic clr_rd,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)           pend <= 1'b0;
        else if (wake_evt) pend <= 1'b1;   // event beats a same-cycle clear
        else if (clr_rd)   pend <= 1'b0;
    end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int CH_N  = NUM_CH,
    parameter int SRC_N = NUM_SRC
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CH_N*SRC_N-1:0] src_req,
    input  logic                  wake_evt,
    input  logic                  rd_en,
    input  logic [3:0]            rd_be,
    output logic [WORD_W-1:0]     rd_data,
    output logic                  irq_out
);
    localparam int CODE_TOP = CODE_BASE + CH_N*CODE_W;

    chan_stat_t       stat [CH_N];
    logic [CH_N-1:0]  sum_vec;
    logic             wake_pend;

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        irq_chan_enc #(.SRC_N(SRC_N)) u_enc (
            .clk  (clk),
            .rst  (rst),
            .req  (src_req[g*SRC_N +: SRC_N]),
            .stat (stat[g])
        );
        assign sum_vec[g] = stat[g].pend;
    end

    irq_wake_flag u_wake (
        .clk      (clk),
        .rst      (rst),
        .wake_evt (wake_evt),
        .clr_rd   (rd_en && rd_be[0]),
        .pend     (wake_pend)
    );

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < CH_N; c++) begin
            rd_data[c] = stat[c].pend;
            rd_data[CODE_BASE + c*CODE_W +: CODE_W] = stat[c].code;
        end
    end

    assign irq_out = (|sum_vec) | wake_pend;

    if (CODE_TOP > WORD_W || CH_N > 8) begin : g_bad_cfg
        initial $error("irq_status_agg: channel fields do not fit the word");
    end
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk
    import irq_agg_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_CH*NUM_SRC-1:0] src_req,
    input logic                      wake_evt,
    input logic                      rd_en,
    input logic [3:0]                rd_be,
    input logic [WORD_W-1:0]         rd_data,
    input logic                      irq_out,
    input logic                      wake_pend
);
    p_reset_zero_r1: assert property (@(posedge clk)
        $past(rst) |-> (rd_data == '0 && !wake_pend));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rd_data[7:4] == 4'h0 && rd_data[31:20] == 12'h0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_c
        // R3 with R4 field placement
        p_sum_code_r3: assert property (@(posedge clk) disable iff (rst)
            rd_data[g] == (rd_data[CODE_BASE + g*CODE_W +: CODE_W] != 3'd0));
        // R5: line status is top priority
        p_line_first_r5: assert property (@(posedge clk) disable iff (rst)
            src_req[g*NUM_SRC] |=> rd_data[CODE_BASE + g*CODE_W +: CODE_W] == 3'd1);
    end

    p_read_keeps_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $stable(src_req)) |=> $stable(rd_data));

    p_wake_set_r7: assert property (@(posedge clk) disable iff (rst)
        wake_evt |=> (wake_pend && irq_out));

    p_wake_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_be[0] && !wake_evt) |=> !wake_pend);

    p_wake_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (wake_pend && !(rd_en && rd_be[0])) |=> wake_pend);

    p_irq_or_r10: assert property (@(posedge clk) disable iff (rst)
        irq_out == ((|rd_data[3:0]) || wake_pend));
endmodule

bind irq_status_agg irq_status_agg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_req   (src_req),
    .wake_evt  (wake_evt),
    .rd_en     (rd_en),
    .rd_be     (rd_be),
    .rd_data   (rd_data),
    .irq_out   (irq_out),
    .wake_pend (wake_pend)
);

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NSR = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NCH*NSR-1:0] src_req = '0;
    logic             wake_evt = 1'b0;
    logic             rd_en = 1'b0;
    logic [3:0]       rd_be = 4'h0;
    logic [31:0]      rd_data;
    logic             irq_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] word;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    logic wake_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_agg u_dut (
        .clk (clk), .rst (rst), .src_req (src_req), .wake_evt (wake_evt),
        .rd_en (rd_en), .rd_be (rd_be), .rd_data (rd_data), .irq_out (irq_out)
    );

    function automatic logic [2:0] ref_code(input logic [NSR-1:0] r);
        for (int i = 0; i < NSR; i++)
            if (r[i]) return 3'(i + 1);
        return 3'd0;
    endfunction

    // Driver: one cycle per call, expected result queued for the monitor.
    task automatic step(input logic [NCH*NSR-1:0] s, input logic wk,
                        input logic rd, input logic [3:0] be, input string tag);
        exp_t e;
        @(negedge clk);
        src_req = s; wake_evt = wk; rd_en = rd; rd_be = be;
        if (wk) wake_m = 1'b1;
        else if (rd && be[0]) wake_m = 1'b0;
        e.word = '0;
        for (int c = 0; c < NCH; c++) begin
            e.word[c] = |s[c*NSR +: NSR];
            e.word[8 + c*3 +: 3] = ref_code(s[c*NSR +: NSR]);
        end
        e.irq = (|e.word[3:0]) | wake_m;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares after each rising edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (rd_data !== e.word || irq_out !== e.irq) begin
                errors++;
                $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                         e.tag, rd_data, irq_out, e.word, e.irq);
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NCH*NSR-1:0] v;
        repeat (3) @(negedge clk);
        checks++;
        if (rd_data !== 32'h0 || irq_out !== 1'b0) begin
            errors++;
            $display("FAIL R1: rd_data=%h irq=%b expected 00000000 0", rd_data, irq_out);
        end
        @(negedge clk); rst = 1'b0;
        step('0, 1'b0, 1'b0, 4'h0, "R1 idle after reset");

        // R5/R4: every single source on every channel
        for (int c = 0; c < NCH; c++)
            for (int b = 0; b < NSR; b++) begin
                v = '0; v[c*NSR + b] = 1'b1;
                step(v, 1'b0, 1'b0, 4'h0, "R3 R4 R5 single source");
            end
        // R5: priority ladder, dropping the top source each step
        for (int b = 0; b < NSR; b++) begin
            v = '0;
            for (int k = b; k < NSR; k++) v[2*NSR + k] = 1'b1;
            step(v, 1'b0, 1'b0, 4'h0, "R5 priority ladder ch2");
        end
        // R2/R3: mixed patterns across channels
        step(20'hFFFFF, 1'b0, 1'b0, 4'h0, "R2 R3 all sources");
        step(20'h84210, 1'b0, 1'b0, 4'h0, "R3 R4 mixed");
        step(20'h0A018, 1'b0, 1'b0, 4'h0, "R3 R4 mixed2");
        // R6: reads leave channel state
        step(20'h0A018, 1'b0, 1'b1, 4'hF, "R6 read all lanes");
        step(20'h0A018, 1'b0, 1'b1, 4'h1, "R6 read lane0");
        step('0, 1'b0, 1'b0, 4'h0, "R3 sources cleared");
        // R7: wake sets only irq_out
        step('0, 1'b1, 1'b0, 4'h0, "R7 wake pending");
        step('0, 1'b0, 1'b0, 4'h0, "R7 wake held");
        // R8: read without lane 0 keeps, with lane 0 clears
        step('0, 1'b0, 1'b1, 4'hE, "R8 read upper lanes keeps wake");
        step('0, 1'b0, 1'b1, 4'h1, "R8 read lane0 clears wake");
        step('0, 1'b0, 1'b0, 4'h0, "R10 idle irq low");
        // R9: wake and clearing read together
        step('0, 1'b1, 1'b1, 4'hF, "R9 wake wins over clear");
        step('0, 1'b0, 1'b0, 4'h0, "R9 wake still held");
        // R10: channel pending with wake cleared
        step(20'h00020, 1'b0, 1'b1, 4'h1, "R10 channel keeps irq");
        step('0, 1'b0, 1'b0, 4'h0, "R10 all clear");
        @(negedge clk); rd_en = 1'b0;
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule